// File: doc/BRIEF.md
# Machine-Mode Trap Entry Unit

This unit sits next to the control path of a small 32-bit core and decides where execution continues when the pipeline raises a synchronous exception or an interrupt line, or retires a return-from-trap. In the cycle after the request it redirects the program counter. For a trap, it also produces the new values of the saved trap PC, the trap cause and the trap value registers, together with a one-cycle write strobe.

Exceptions land on the base of the trap vector with no offset. Interrupts are dispatched through a vector table that is indexed by the interrupt number. The trap value register holds something that depends on the cause: the data address for load and store faults, the instruction word for an illegal instruction, and zero for everything else. A return redirects to the saved trap PC that the unit holds. If several requests arrive together, a fixed order picks the one that is served.

Top module: `trap_entry_unit`

## Requirements
- R1: An exception redirects to `{mtvec_i[31:2], 2'b00}`. The two low bits of the vector register are a mode field and never reach the target.
- R2: An interrupt redirects to `{mtvec_i[31:2], 2'b00} + 4*N`, where N is the index of the interrupt line being served.
- R3: The cause output has bit 31 set for an interrupt, with bits [30:0] equal to the line index N. For an exception, bit 31 is clear and bits [30:0] equal the 5-bit exception code.
- R4: For exception codes 4, 5, 6 and 7 (load misaligned, load fault, store misaligned, store fault), the trap value is `fault_addr_i`.
- R5: For exception code 2 (illegal instruction), the trap value is `instr_i`.
- R6: Every other exception code and every interrupt writes a trap value of zero.
- R7: The saved trap PC is `pc_i` with bits [1:0] cleared for an exception, and `next_pc_i` with bits [1:0] cleared for an interrupt.
- R8: When an exception and an interrupt are requested in the same cycle, only the exception is taken.
- R9: When several interrupt lines are high, the line with the highest index is served.
- R10: A return (`mret_i` with no trap pending) redirects to the saved trap PC held before it and leaves the saved PC, cause and trap value unchanged. A trap in the same cycle takes precedence over a return.
- R11: Every result appears on the outputs one clock after the request. `redirect_o` and `csr_we_o` are single-cycle pulses and stay low in a cycle with no request.
- R12: Reset clears the redirect and write strobes and the saved PC, cause and trap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Exception code |
| pc_i | input | 32 | PC of the instruction in the trapping stage |
| next_pc_i | input | 32 | PC of the next instruction (saved on interrupts) |
| fault_addr_i | input | 32 | Data address of the failing load or store |
| instr_i | input | 32 | Raw instruction word |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| mret_i | input | 1 | Return-from-trap request |
| mtvec_i | input | 32 | Trap vector register |
| redirect_o | output | 1 | PC redirect strobe |
| redirect_pc_o | output | 32 | Redirect target |
| csr_we_o | output | 1 | Trap CSR write strobe |
| mepc_o | output | 32 | Saved trap PC |
| mcause_o | output | 32 | Trap cause |
| mtval_o | output | 32 | Trap value |

## Verification
Every result (redirect strobe and target, write strobe, saved PC, cause and trap value) is due exactly one rising edge after the request is presented. Nothing is combinational from input to output. The bench drives a request on a falling edge. Its behavioural model computes what should appear after the next rising edge, and the comparison is made on the following falling edge, just before the next request is applied. So each comparison lines up with the single register stage, and an idle cycle is checked for the absence of pulses in the same way.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam int XLEN   = 32;
  localparam int CODE_W = 5;

  typedef enum logic [1:0] {
    TK_NONE = 2'd0,
    TK_EXC  = 2'd1,
    TK_IRQ  = 2'd2,
    TK_RET  = 2'd3
  } trap_kind_e;

  localparam logic [CODE_W-1:0] CODE_ILLEGAL     = 5'd2;
  localparam logic [CODE_W-1:0] CODE_LOAD_MISAL  = 5'd4;
  localparam logic [CODE_W-1:0] CODE_LOAD_FAULT  = 5'd5;
  localparam logic [CODE_W-1:0] CODE_STORE_MISAL = 5'd6;
  localparam logic [CODE_W-1:0] CODE_STORE_FAULT = 5'd7;

  // Vector base: mode field in the two low bits is dropped.
  function automatic logic [XLEN-1:0] vec_base(input logic [XLEN-1:0] tvec);
    return {tvec[XLEN-1:2], 2'b00};
  endfunction

  // Vectored dispatch: base plus one word per interrupt number.
  function automatic logic [XLEN-1:0] vec_slot(input logic [XLEN-1:0] tvec,
                                               input logic [XLEN-1:0] num);
    return vec_base(tvec) + {num[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] word_align(input logic [XLEN-1:0] a);
    return {a[XLEN-1:2], 2'b00};
  endfunction

  function automatic logic is_mem_code(input logic [CODE_W-1:0] c);
    return (c == CODE_LOAD_MISAL) || (c == CODE_LOAD_FAULT) ||
           (c == CODE_STORE_MISAL) || (c == CODE_STORE_FAULT);
  endfunction

  function automatic logic [XLEN-1:0] pick_tval(input logic [CODE_W-1:0] c,
                                                input logic [XLEN-1:0] addr,
                                                input logic [XLEN-1:0] insn);
    logic [XLEN-1:0] v;
    if (is_mem_code(c))            v = addr;
    else if (c == CODE_ILLEGAL)    v = insn;
    else                           v = '0;
    return v;
  endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               exc_valid_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               mret_i,
  output trap_kind_e         kind_o,
  output logic [IDW-1:0]     irq_id_o,
  output logic [NUM_IRQ-1:0] grant_o
);

  logic [NUM_IRQ-1:0] grant;
  logic               irq_any;

  // One-hot grant: a line wins when no higher-indexed line is active.
  genvar gk;
  generate
    for (gk = 0; gk < NUM_IRQ; gk++) begin : g_grant
      if (gk == NUM_IRQ - 1) begin : g_top
        assign grant[gk] = irq_i[gk];
      end else begin : g_low
        assign grant[gk] = irq_i[gk] & ~(|irq_i[NUM_IRQ-1:gk+1]);
      end
    end
  endgenerate

  assign irq_any = |irq_i;

  always_comb begin
    irq_id_o = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (grant[k]) irq_id_o = irq_id_o | IDW'(k);
    end
  end

  always_comb begin
    if (exc_valid_i)      kind_o = TK_EXC;
    else if (irq_any)     kind_o = TK_IRQ;
    else if (mret_i)      kind_o = TK_RET;
    else                  kind_o = TK_NONE;
  end

  assign grant_o = grant;

endmodule

// File: rtl/trap_info_gen.sv
module trap_info_gen
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  trap_kind_e        kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [IDW-1:0]    irq_id_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   next_pc_i,
  input  logic [XLEN-1:0]   fault_addr_i,
  input  logic [XLEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   mtvec_i,
  input  logic [XLEN-1:0]   mepc_q_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic              csr_we_o,
  output logic [XLEN-1:0]   mepc_o,
  output logic [XLEN-1:0]   mcause_o,
  output logic [XLEN-1:0]   mtval_o
);

  logic [XLEN-1:0] irq_num;
  assign irq_num = XLEN'(irq_id_i);

  always_comb begin
    redirect_o = 1'b0;
    csr_we_o   = 1'b0;
    target_o   = '0;
    mepc_o     = '0;
    mcause_o   = '0;
    mtval_o    = '0;
    unique case (kind_i)
      TK_EXC: begin
        redirect_o = 1'b1;
        csr_we_o   = 1'b1;
        target_o   = vec_base(mtvec_i);
        mepc_o     = word_align(pc_i);
        mcause_o   = {1'b0, {(XLEN-1-CODE_W){1'b0}}, exc_code_i};
        mtval_o    = pick_tval(exc_code_i, fault_addr_i, instr_i);
      end
      TK_IRQ: begin
        redirect_o = 1'b1;
        csr_we_o   = 1'b1;
        target_o   = vec_slot(mtvec_i, irq_num);
        mepc_o     = word_align(next_pc_i);
        mcause_o   = {1'b1, irq_num[XLEN-2:0]};
        mtval_o    = '0;
      end
      TK_RET: begin
        redirect_o = 1'b1;
        target_o   = mepc_q_i;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               exc_valid_i,
  input  logic [4:0]         exc_code_i,
  input  logic [31:0]        pc_i,
  input  logic [31:0]        next_pc_i,
  input  logic [31:0]        fault_addr_i,
  input  logic [31:0]        instr_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               mret_i,
  input  logic [31:0]        mtvec_i,
  output logic               redirect_o,
  output logic [31:0]        redirect_pc_o,
  output logic               csr_we_o,
  output logic [31:0]        mepc_o,
  output logic [31:0]        mcause_o,
  output logic [31:0]        mtval_o
);

  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  // Named internal events
  trap_kind_e         trap_kind;
  logic [IDW-1:0]     irq_id;
  logic [NUM_IRQ-1:0] irq_grant;
  logic               take_trap;
  logic               nxt_redirect, nxt_we;
  logic [31:0]        nxt_target, nxt_mepc, nxt_mcause, nxt_mtval;

  logic        redirect_q, we_q;
  logic [31:0] target_q, mepc_q, mcause_q, mtval_q;

  trap_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .exc_valid_i (exc_valid_i),
    .irq_i       (irq_i),
    .mret_i      (mret_i),
    .kind_o      (trap_kind),
    .irq_id_o    (irq_id),
    .grant_o     (irq_grant)
  );

  trap_info_gen #(.NUM_IRQ(NUM_IRQ)) u_info (
    .kind_i       (trap_kind),
    .exc_code_i   (exc_code_i),
    .irq_id_i     (irq_id),
    .pc_i         (pc_i),
    .next_pc_i    (next_pc_i),
    .fault_addr_i (fault_addr_i),
    .instr_i      (instr_i),
    .mtvec_i      (mtvec_i),
    .mepc_q_i     (mepc_q),
    .redirect_o   (nxt_redirect),
    .target_o     (nxt_target),
    .csr_we_o     (nxt_we),
    .mepc_o       (nxt_mepc),
    .mcause_o     (nxt_mcause),
    .mtval_o      (nxt_mtval)
  );

  assign take_trap = nxt_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      we_q       <= 1'b0;
      target_q   <= '0;
      mepc_q     <= '0;
      mcause_q   <= '0;
      mtval_q    <= '0;
    end else begin
      redirect_q <= nxt_redirect;
      we_q       <= take_trap;
      if (nxt_redirect) target_q <= nxt_target;
      if (take_trap) begin
        mepc_q   <= nxt_mepc;
        mcause_q <= nxt_mcause;
        mtval_q  <= nxt_mtval;
      end
    end
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = target_q;
  assign csr_we_o      = we_q;
  assign mepc_o        = mepc_q;
  assign mcause_o      = mcause_q;
  assign mtval_o       = mtval_q;

endmodule

// File: rtl/trap_entry_checks.sv
module trap_entry_checks #(
  parameter int NUM_IRQ = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               exc_valid_i,
  input logic [31:0]        pc_i,
  input logic [NUM_IRQ-1:0] irq_i,
  input logic               mret_i,
  input logic [31:0]        mtvec_i,
  input logic               redirect_o,
  input logic [31:0]        redirect_pc_o,
  input logic               csr_we_o,
  input logic [31:0]        mepc_o,
  input logic [31:0]        mcause_o,
  input logic [NUM_IRQ-1:0] irq_grant,
  input logic               take_trap
);

  logic any_req;
  assign any_req = exc_valid_i | (|irq_i) | mret_i;

  // R11: a request produces a redirect one cycle later
  a_r11_redirect_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> redirect_o);

  // R11: no request, no pulse
  a_r11_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_req |=> (!redirect_o && !csr_we_o));

  // R1: exception target is the masked vector base
  a_r1_exc_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> (redirect_pc_o == {$past(mtvec_i[31:2]), 2'b00}));

  // R3 / R8: an exception never records an interrupt cause, even with irqs pending
  a_r8_exc_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_valid_i && (|irq_i)) |=> (!mcause_o[31] &&
                                   mepc_o == {$past(pc_i[31:2]), 2'b00}));

  // R2: interrupt target follows the recorded cause number
  a_r2_irq_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i && (|irq_i)) |=> (mcause_o[31] &&
      redirect_pc_o == ({$past(mtvec_i[31:2]), 2'b00} + {mcause_o[29:0], 2'b00})));

  // R7: the saved PC is always word aligned after a trap
  a_r7_mepc_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> (mepc_o[1:0] == 2'b00));

  // R9: the arbiter grants at most one line, and only when a line is active
  a_r9_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_grant) && ((|irq_i) == (|irq_grant)));

  // R10: a bare return targets the previous saved PC and writes no CSR
  a_r10_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mret_i && !exc_valid_i && !(|irq_i)) |=>
      (!csr_we_o && redirect_pc_o == $past(mepc_o) && $stable(mcause_o)));

  // R8/R10: a trap is taken exactly when an exception or interrupt is present
  a_r8_trap_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trap == (exc_valid_i | (|irq_i)));

endmodule

bind trap_entry_unit trap_entry_checks #(.NUM_IRQ(NUM_IRQ)) u_checks (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exc_valid_i   (exc_valid_i),
  .pc_i          (pc_i),
  .irq_i         (irq_i),
  .mret_i        (mret_i),
  .mtvec_i       (mtvec_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .csr_we_o      (csr_we_o),
  .mepc_o        (mepc_o),
  .mcause_o      (mcause_o),
  .irq_grant     (irq_grant),
  .take_trap     (take_trap)
);

// File: tb/trap_entry_unit_bench.sv
module trap_entry_unit_bench;

  localparam int NIRQ = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            exc_v = 1'b0;
  logic [4:0]      exc_c = '0;
  logic [31:0]     pc = '0, npc = '0, faddr = '0, insn = '0, tvec = '0;
  logic [NIRQ-1:0] irq = '0;
  logic            ret = 1'b0;
  logic            redir, we;
  logic [31:0]     rpc, mepc, mcause, mtval;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state (expected outputs after the next edge)
  bit          e_redir = 0, e_we = 0;
  logic [31:0] e_rpc = '0, e_mepc = '0, e_mcause = '0, e_mtval = '0;
  string       e_tag = "R12";

  always #2 clk = ~clk;

  trap_entry_unit #(.NUM_IRQ(NIRQ)) u_trap_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_v), .exc_code_i(exc_c),
    .pc_i(pc), .next_pc_i(npc), .fault_addr_i(faddr), .instr_i(insn),
    .irq_i(irq), .mret_i(ret), .mtvec_i(tvec),
    .redirect_o(redir), .redirect_pc_o(rpc), .csr_we_o(we),
    .mepc_o(mepc), .mcause_o(mcause), .mtval_o(mtval)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(e_tag, "redirect", {31'b0, redir}, {31'b0, e_redir});
    chk(e_tag, "csr_we", {31'b0, we}, {31'b0, e_we});
    if (e_redir) chk(e_tag, "target", rpc, e_rpc);
    chk(e_tag, "mepc", mepc, e_mepc);
    chk(e_tag, "mcause", mcause, e_mcause);
    chk(e_tag, "mtval", mtval, e_mtval);
  endtask

  // Behavioural model of one request
  task automatic model(string tag);
    int win;
    e_tag = tag;
    win = -1;
    for (int k = 0; k < NIRQ; k++) if (irq[k]) win = k;
    e_we = 0;
    e_redir = 0;
    if (exc_v) begin
      e_redir = 1; e_we = 1;
      e_rpc = tvec & 32'hFFFF_FFFC;
      e_mepc = pc & 32'hFFFF_FFFC;
      e_mcause = {27'd0, exc_c};
      if (exc_c >= 5'd4 && exc_c <= 5'd7) e_mtval = faddr;
      else if (exc_c == 5'd2)             e_mtval = insn;
      else                                e_mtval = 0;
    end else if (win >= 0) begin
      e_redir = 1; e_we = 1;
      e_rpc = (tvec & 32'hFFFF_FFFC) + 32'(win) * 4;
      e_mepc = npc & 32'hFFFF_FFFC;
      e_mcause = 32'h8000_0000 | 32'(win);
      e_mtval = 0;
    end else if (ret) begin
      e_redir = 1;
      e_rpc = e_mepc;
    end
  endtask

  task automatic step(string tag, bit ev, logic [4:0] ec, logic [31:0] p,
                      logic [31:0] np, logic [31:0] fa, logic [31:0] in,
                      logic [NIRQ-1:0] iq, bit r, logic [31:0] tv);
    @(negedge clk);
    compare_all();
    exc_v = ev; exc_c = ec; pc = p; npc = np; faddr = fa; insn = in;
    irq = iq; ret = r; tvec = tv;
    model(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();               // R12 reset values
    rst_n = 1'b1;
    // R6 ecall: zero trap value
    step("R6",  1, 5'd11, 32'h0000_1004, 32'h0000_1008, 32'hDEAD_0000, 32'h0000_0073, '0, 0, 32'h0000_8000);
    // R5 illegal instruction
    step("R5",  1, 5'd2,  32'h0000_2010, 32'h0000_2014, 32'h1111_1111, 32'hFFFF_FFFF, '0, 0, 32'h0000_8001);
    // R4 load fault and store misaligned
    step("R4",  1, 5'd5,  32'h0000_3000, 32'h0000_3004, 32'hCAFE_0012, 32'h0001_2083, '0, 0, 32'h0000_8000);
    step("R4",  1, 5'd6,  32'h0000_3100, 32'h0000_3104, 32'h0000_0043, 32'h0001_2023, '0, 0, 32'h0000_8000);
    // R1 vector mode bits masked for exceptions
    step("R1",  1, 5'd3,  32'h0000_4000, 32'h0000_4004, 32'h0, 32'h0010_0073, '0, 0, 32'h0001_0003);
    // R7 unaligned pc cleared
    step("R7",  1, 5'd0,  32'h0000_5006, 32'h0000_5008, 32'h0, 32'h0, '0, 0, 32'h0000_8000);
    // R11 idle cycle: no pulses, CSRs held
    step("R11", 0, 5'd0,  32'h0, 32'h0, 32'h0, 32'h0, '0, 0, 32'h0000_8000);
    // R2 / R3 single interrupt, vectored
    step("R2",  0, 5'd0,  32'h0000_6000, 32'h0000_6006, 32'h0, 32'h0, 16'h0080, 0, 32'h0000_8001);
    step("R3",  0, 5'd0,  32'h0000_6100, 32'h0000_6104, 32'h0, 32'h0, 16'h0008, 0, 32'h0000_8000);
    // R9 multiple lines: highest index wins
    step("R9",  0, 5'd0,  32'h0000_7000, 32'h0000_7004, 32'h0, 32'h0, 16'h0888, 0, 32'h0000_9000);
    step("R9",  0, 5'd0,  32'h0000_7100, 32'h0000_7104, 32'h0, 32'h0, 16'h8001, 0, 32'h0000_9000);
    // R8 exception beats interrupt
    step("R8",  1, 5'd7,  32'h0000_7200, 32'h0000_7204, 32'hABCD_0004, 32'h0, 16'h0800, 0, 32'h0000_9000);
    // R10 return redirects to saved pc, CSRs held
    step("R10", 0, 5'd0,  32'h0, 32'h0, 32'h0, 32'h0, '0, 1, 32'h0000_9000);
    // R10 trap beats return
    step("R10", 1, 5'd11, 32'h0000_7300, 32'h0000_7304, 32'h0, 32'h0, '0, 1, 32'h0000_9000);
    step("R10", 0, 5'd0,  32'h0, 32'h0, 32'h0, 32'h0, '0, 1, 32'h0000_9000);
    // R6 interrupt writes zero trap value after a nonzero one
    step("R5",  1, 5'd2,  32'h0000_7400, 32'h0000_7404, 32'h0, 32'h1234_5678, '0, 0, 32'h0000_9000);
    step("R6",  0, 5'd0,  32'h0000_7500, 32'h0000_7504, 32'h0, 32'h0, 16'h0002, 0, 32'h0000_9000);
    // R11 back-to-back then idle
    step("R11", 0, 5'd0,  32'h0, 32'h0, 32'h0, 32'h0, '0, 0, 32'h0000_9000);
    step("R11", 0, 5'd0,  32'h0, 32'h0, 32'h0, 32'h0, '0, 0, 32'h0000_9000);
    @(negedge clk);
    compare_all();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule